// File: doc/BRIEF.md
# Programmable Counter Array

The block is a timer peripheral built around one free-running 16-bit up-counter. Its low byte is called CL and its high byte CH. The counter steps from one of four sources. The sources are the system clock divided by two, the system clock divided by four, single-cycle overflow pulses from a neighbouring timer, and rising edges on an external count input. A run bit in the control register gates all four sources.

Five compare/capture units watch the counter. Each unit has its own 16-bit compare/capture register and its own mode. The modes work as follows:
- Capture modes latch the counter on a rising edge, a falling edge or either edge of the unit's pin.
- The software-timer mode raises the unit's flag when the counter steps onto the compare value.
- The toggle mode inverts the unit's output on each such match.
- The PWM mode drives the output high while CL is below the low compare byte.
- The last unit also has a watchdog mode. In that mode a match raises a reset request, unless software moves the compare value ahead first.

Software reaches all state through a byte-wide write port and a combinational read port.

Each unit's mode register is its state. The mode codes are `M_OFF`, `M_CAP_RISE`, `M_CAP_FALL`, `M_CAP_BOTH`, `M_TIMER`, `M_TOGGLE`, `M_PWM` and `M_WDOG`. The only transition between them is a software write of the unit's mode register. From any mode, that write moves the unit to the written mode. The one exception is `M_WDOG` on units other than the last, which behaves as `M_OFF`. Inside a mode, the events are:
- capture on a synchronized pin edge;
- a match when the counter steps onto the compare value;
- a PWM reload when CL wraps.

The counter source select is a second small state held in `src_q`. Its values are `SRC_DIV2`, `SRC_DIV4`, `SRC_T0` and `SRC_EXT`, and a write of the control register changes it.

Top module: `pca_array`

## Requirements
- R1: After reset the counter is 0, the control register reads 0, all flags, outputs, interrupt lines and the watchdog request are 0, and all unit modes are off.
- R2: The control register is at address 0, with the source in bits [1:0] and run in bit 7. With run set, source 0 advances the counter once every 2 clocks and source 1 advances it once every 4 clocks, so any 40 consecutive clocks add 20 and 10 respectively.
- R3: With source 2, the counter advances once per clock on which `t0_ovf` is high. A step from CL=0xFF carries into CH.
- R4: With source 3, `ext_in` passes through two synchronizer flip-flops and the counter advances exactly once per rising edge of `ext_in`.
- R5: CL is read and written at address 1 and CH at address 2. A software write replaces the byte. With run clear, the counter holds its value.
- R6: Unit n has its mode at address 8+4n, its low compare byte at 8+4n+1 and its high compare byte at 8+4n+2. The mode codes are 1 (capture on rise), 2 (capture on fall) and 3 (capture on both edges). On a matching synchronized pin edge the unit copies the counter into its compare register and sets its flag. Edges of the other polarity change neither.
- R7: The flags of units 0 to 4 read as bits 0 to 4 at address 3 and drive `irq`. A flag stays set until software writes a 1 to its bit at address 3. Writing 0 leaves the flag set.
- R8: In mode 4 (software timer), the unit's flag sets when the counter steps onto the 16-bit compare value. It stays clear before that.
- R9: In mode 5 (toggle), the unit's output inverts and its flag sets each time the counter steps onto the compare value.
- R10: In mode 6 (PWM), the output is high when CL is less than the low compare byte, and low when CL is equal to or greater than it.
- R11: In PWM mode, the high compare byte is copied into the low compare byte on the clock where CL wraps from 0xFF to 0. The duty cycle therefore changes only at period boundaries.
- R12: In mode 7, only unit 4 acts as a watchdog. When the counter steps onto its compare value, `wdt_rst` rises and stays high until reset. Moving the compare value ahead before the match avoids the request. Mode 7 on other units does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the divided sources derive from it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (5) | Register write address |
| wr_data | input | DW (8) | Register write data |
| rd_addr | input | AW (5) | Register read address |
| rd_data | output | DW (8) | Combinational read data |
| t0_ovf | input | 1 | Overflow pulse from the neighbouring timer |
| ext_in | input | 1 | Asynchronous external count input |
| cap_in | input | NMOD (5) | Asynchronous capture pins, one per unit |
| cmp_out | output | NMOD (5) | Toggle/PWM output pins, one per unit |
| irq | output | NMOD (5) | Sticky per-unit interrupt flags |
| wdt_rst | output | 1 | Watchdog reset request |

## Verification
The assertions watch several rules on every clock:
- the counter holds when nothing advances or writes it;
- CL wraps into CH correctly;
- a qualified capture edge or timer match always leaves the flag set;
- a toggle match always flips the output;
- the PWM output is never high with CL at or above the low compare byte;
- the watchdog request never drops.

Only the directed scenarios can show the rest:
- the step rates of the two divided sources;
- the one-step-per-edge behaviour of the external input;
- the exact values a capture latches;
- that edges of the wrong polarity and writes of 0 to the flag register have no effect;
- the reload at CL wrap;
- that a moved compare value, or mode 7 on a lower unit, keeps the request low.

// File: rtl/pca_pkg.sv
package pca_pkg;
    typedef enum logic [1:0] {
        SRC_DIV2 = 2'd0,
        SRC_DIV4 = 2'd1,
        SRC_T0   = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        M_OFF      = 3'd0,
        M_CAP_RISE = 3'd1,
        M_CAP_FALL = 3'd2,
        M_CAP_BOTH = 3'd3,
        M_TIMER    = 3'd4,
        M_TOGGLE   = 3'd5,
        M_PWM      = 3'd6,
        M_WDOG     = 3'd7
    } mode_e;

    localparam int A_CTRL   = 0;
    localparam int A_CL     = 1;
    localparam int A_CH     = 2;
    localparam int A_FLAG   = 3;
    localparam int A_UNIT0  = 8;
    localparam int A_STRIDE = 4;
endpackage

// File: rtl/pca_timebase.sv
module pca_timebase
    import pca_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctrl,
    input  logic            wr_cl,
    input  logic            wr_ch,
    input  logic [DW-1:0]   wr_data,
    input  logic            t0_ovf,
    input  logic            ext_in,
    output src_e            src_q,
    output logic            run_q,
    output logic [2*DW-1:0] cnt,
    output logic            adv,
    output logic            wrap
);
    localparam int CW = 2 * DW;

    logic [1:0] pre;
    logic [2:0] ext_s;
    logic       ext_rise;
    logic       sel_tick;
    logic       tick;
    logic       sw;

    assign sw       = wr_cl || wr_ch;
    assign ext_rise = ext_s[1] && !ext_s[2];

    always_comb begin
        unique case (src_q)
            SRC_DIV2: sel_tick = pre[0];
            SRC_DIV4: sel_tick = &pre;
            SRC_T0:   sel_tick = t0_ovf;
            SRC_EXT:  sel_tick = ext_rise;
            default:  sel_tick = 1'b0;
        endcase
        tick = sel_tick && run_q;
        wrap = tick && !sw && (cnt[DW-1:0] == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            ext_s <= '0;
            src_q <= SRC_DIV2;
            run_q <= 1'b0;
            cnt   <= '0;
            adv   <= 1'b0;
        end else begin
            pre   <= pre + 2'd1;
            ext_s <= {ext_s[1:0], ext_in};
            adv   <= tick && !sw;
            if (wr_ctrl) begin
                src_q <= src_e'(wr_data[1:0]);
                run_q <= wr_data[DW-1];
            end
            if (wr_cl) cnt[DW-1:0]  <= wr_data;
            if (wr_ch) cnt[CW-1:DW] <= wr_data;
            if (tick && !sw) cnt <= cnt + CW'(1);
        end
    end

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !sw) |=> $stable(cnt));

    // R3
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !sw && cnt[DW-1:0] == '1) |=>
        (cnt[DW-1:0] == '0 && cnt[CW-1:DW] == $past(cnt[CW-1:DW]) + DW'(1)));
endmodule

// File: rtl/pca_unit.sv
module pca_unit
    import pca_pkg::*;
#(
    parameter int DW      = 8,
    parameter bit WDOG_OK = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            wrap,
    input  logic [2*DW-1:0] cnt,
    input  logic            pin_in,
    input  logic            wr_mode,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wr_data,
    input  logic            clr_flag,
    output mode_e           mode_q,
    output logic [2*DW-1:0] ccap,
    output logic            flag,
    output logic            pin_out,
    output logic            wdt_q
);
    localparam int CW = 2 * DW;

    logic [1:0] sy;
    logic       sy_d;
    logic       rise;
    logic       fall;
    logic       hit;
    logic       pwm;
    logic       tog_q;
    mode_e      eff;

    assign rise = sy[1] && !sy_d;
    assign fall = !sy[1] && sy_d;
    assign hit  = adv && (cnt == ccap);
    assign pwm  = cnt[DW-1:0] < ccap[DW-1:0];
    assign eff  = (mode_q == M_WDOG && !WDOG_OK) ? M_OFF : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy     <= '0;
            sy_d   <= 1'b0;
            mode_q <= M_OFF;
            ccap   <= '0;
            flag   <= 1'b0;
            tog_q  <= 1'b0;
            wdt_q  <= 1'b0;
        end else begin
            sy   <= {sy[0], pin_in};
            sy_d <= sy[1];
            if (wr_mode)  mode_q        <= mode_e'(wr_data[2:0]);
            if (wr_lo)    ccap[DW-1:0]  <= wr_data;
            if (wr_hi)    ccap[CW-1:DW] <= wr_data;
            if (clr_flag) flag          <= 1'b0;
            unique case (eff)
                M_CAP_RISE: if (rise) begin ccap <= cnt; flag <= 1'b1; end
                M_CAP_FALL: if (fall) begin ccap <= cnt; flag <= 1'b1; end
                M_CAP_BOTH: if (rise || fall) begin ccap <= cnt; flag <= 1'b1; end
                M_TIMER:    if (hit) flag <= 1'b1;
                M_TOGGLE:   if (hit) begin flag <= 1'b1; tog_q <= !tog_q; end
                M_PWM:      if (wrap) ccap[DW-1:0] <= ccap[CW-1:DW];
                M_WDOG:     if (hit) wdt_q <= 1'b1;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (eff)
            M_PWM:   pin_out = pwm;
            default: pin_out = tog_q;
        endcase
    end

    // R6
    cap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((eff == M_CAP_RISE && rise) || (eff == M_CAP_FALL && fall)) |=> flag);

    // R8
    timer_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (eff == M_TIMER && hit) |=> flag);

    // R9
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (eff == M_TOGGLE && hit && !wr_mode) |=> (pin_out != $past(pin_out)));

    // R10
    pwm_low_chk: assert property (@(posedge clk) disable iff (rst)
        (eff == M_PWM && cnt[DW-1:0] >= ccap[DW-1:0]) |-> !pin_out);

    // R12
    wdt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_q |=> wdt_q);
endmodule

// File: rtl/pca_array.sv
module pca_array
    import pca_pkg::*;
#(
    parameter int NMOD = 5,
    parameter int AW   = 5,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            t0_ovf,
    input  logic            ext_in,
    input  logic [NMOD-1:0] cap_in,
    output logic [NMOD-1:0] cmp_out,
    output logic [NMOD-1:0] irq,
    output logic            wdt_rst
);
    localparam int CW = 2 * DW;

    logic [CW-1:0]   cnt;
    logic            adv;
    logic            wrap;
    logic            run;
    src_e            src;
    logic [CW-1:0]   ccap [NMOD];
    mode_e           mode [NMOD];
    logic [NMOD-1:0] flag;
    logic [NMOD-1:0] wdt;
    logic            wr_clr;

    assign wr_clr  = wr_en && (wr_addr == AW'(A_FLAG));
    assign irq     = flag;
    assign wdt_rst = |wdt;

    pca_timebase #(.DW(DW)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_en && (wr_addr == AW'(A_CTRL))),
        .wr_cl   (wr_en && (wr_addr == AW'(A_CL))),
        .wr_ch   (wr_en && (wr_addr == AW'(A_CH))),
        .wr_data (wr_data),
        .t0_ovf  (t0_ovf),
        .ext_in  (ext_in),
        .src_q   (src),
        .run_q   (run),
        .cnt     (cnt),
        .adv     (adv),
        .wrap    (wrap)
    );

    for (genvar g = 0; g < NMOD; g++) begin : g_unit
        localparam logic [AW-1:0] BASE = AW'(A_UNIT0 + A_STRIDE * g);
        pca_unit #(.DW(DW), .WDOG_OK(g == NMOD - 1)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .adv      (adv),
            .wrap     (wrap),
            .cnt      (cnt),
            .pin_in   (cap_in[g]),
            .wr_mode  (wr_en && (wr_addr == BASE)),
            .wr_lo    (wr_en && (wr_addr == BASE + AW'(1))),
            .wr_hi    (wr_en && (wr_addr == BASE + AW'(2))),
            .wr_data  (wr_data),
            .clr_flag (wr_clr && wr_data[g]),
            .mode_q   (mode[g]),
            .ccap     (ccap[g]),
            .flag     (flag[g]),
            .pin_out  (cmp_out[g]),
            .wdt_q    (wdt[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CTRL)) begin
            rd_data[DW-1] = run;
            rd_data[1:0]  = src;
        end
        if (rd_addr == AW'(A_CL))   rd_data = cnt[DW-1:0];
        if (rd_addr == AW'(A_CH))   rd_data = cnt[CW-1:DW];
        if (rd_addr == AW'(A_FLAG)) rd_data[NMOD-1:0] = flag;
        for (int i = 0; i < NMOD; i++) begin
            if (rd_addr == AW'(A_UNIT0 + A_STRIDE * i))     rd_data = DW'(mode[i]);
            if (rd_addr == AW'(A_UNIT0 + A_STRIDE * i + 1)) rd_data = ccap[i][DW-1:0];
            if (rd_addr == AW'(A_UNIT0 + A_STRIDE * i + 2)) rd_data = ccap[i][CW-1:DW];
        end
    end
endmodule

// File: tb/sim_pca_array.sv
`timescale 1ns/1ps
module sim_pca_array;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       t0_ovf = 1'b0;
    logic       ext_in = 1'b0;
    logic [4:0] cap_in = '0;
    logic [4:0] cmp_out;
    logic [4:0] irq;
    logic       wdt_rst;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    pca_array u0 (.*);

    always #10 clk = !clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = 5'(a);
        #1;
        v = rd_data;
    endtask

    task automatic t0_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); t0_ovf = 1'b1;
            @(negedge clk); t0_ovf = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cnt(input int v);
        wr(1, v & 8'hFF);
        wr(2, (v >> 8) & 8'hFF);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(0, v); check("R1 ctrl", 16'(v), 16'h00);
        rd(1, v); check("R1 CL", 16'(v), 16'h00);
        rd(3, v); check("R1 flags", 16'(v), 16'h00);
        rd(8, v); check("R1 mode0", 16'(v), 16'h00);
        check("R1 outs", 16'({cmp_out, irq, wdt_rst}), 16'h0);
    endtask

    task automatic t_div;
        logic [7:0] v;
        wr(0, 8'h00); set_cnt(0);
        wr(0, 8'h80);
        repeat (38) @(negedge clk);
        wr(0, 8'h00);
        rd(1, v); check("R2 div2 count", 16'(v), 16'd20);
        set_cnt(0);
        wr(0, 8'h81);
        repeat (38) @(negedge clk);
        wr(0, 8'h01);
        rd(1, v); check("R2 div4 count", 16'(v), 16'd10);
        rd(0, v); check("R2 ctrl readback", 16'(v), 16'h01);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        wr(0, 8'h00); set_cnt(16'hA55A);
        repeat (20) @(negedge clk);
        rd(1, v); check("R5 CL hold", 16'(v), 16'h5A);
        rd(2, v); check("R5 CH hold", 16'(v), 16'hA5);
    endtask

    task automatic t_t0;
        logic [7:0] v;
        wr(0, 8'h82); set_cnt(16'h12FA);
        t0_pulses(7);
        rd(1, v); check("R3 CL after carry", 16'(v), 16'h01);
        rd(2, v); check("R3 CH after carry", 16'(v), 16'h13);
    endtask

    task automatic t_ext;
        logic [7:0] v;
        wr(0, 8'h03); set_cnt(0); wr(0, 8'h83);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_in = 1'b1;
            repeat (4) @(negedge clk); ext_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(0, 8'h03);
        rd(1, v); check("R4 ext edges", 16'(v), 16'd5);
    endtask

    task automatic t_timer;
        logic [7:0] v;
        wr(0, 8'h82); set_cnt(0);
        wr(13, 8'h05); wr(14, 8'h00); wr(12, 4);
        t0_pulses(4);
        check("R8 no flag before match", 16'(irq[1]), 16'd0);
        t0_pulses(1);
        check("R8 flag on match", 16'(irq[1]), 16'd1);
        wr(3, 8'h00);
        rd(3, v); check("R7 zero write keeps flag", 16'(v[1]), 16'd1);
        wr(3, 8'h02);
        rd(3, v); check("R7 one write clears flag", 16'(v[1]), 16'd0);
        wr(12, 0);
    endtask

    task automatic t_toggle;
        wr(0, 8'h82); set_cnt(0);
        wr(17, 8'h03); wr(18, 8'h00); wr(16, 5);
        t0_pulses(2);
        check("R9 out before match", 16'(cmp_out[2]), 16'd0);
        t0_pulses(1);
        check("R9 out after match", 16'(cmp_out[2]), 16'd1);
        check("R9 flag on match", 16'(irq[2]), 16'd1);
        set_cnt(2);
        t0_pulses(1);
        check("R9 out second match", 16'(cmp_out[2]), 16'd0);
        wr(16, 0); wr(3, 8'h1F);
    endtask

    task automatic t_pwm;
        logic [7:0] v;
        wr(0, 8'h82);
        wr(21, 8'h40); wr(22, 8'h40); wr(20, 6);
        set_cnt(16'h003F); check("R10 below -> high", 16'(cmp_out[3]), 16'd1);
        set_cnt(16'h0040); check("R10 equal -> low", 16'(cmp_out[3]), 16'd0);
        set_cnt(16'h0041); check("R10 above -> low", 16'(cmp_out[3]), 16'd0);
        wr(22, 8'h80);
        set_cnt(16'h007F); check("R11 no reload mid-period", 16'(cmp_out[3]), 16'd0);
        set_cnt(16'h00FF);
        t0_pulses(1);
        rd(21, v); check("R11 reload at wrap", 16'(v), 16'h80);
        set_cnt(16'h017F); check("R11 new duty high", 16'(cmp_out[3]), 16'd1);
        set_cnt(16'h0180); check("R11 new duty low", 16'(cmp_out[3]), 16'd0);
        wr(20, 0);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        wr(0, 8'h82); wr(3, 8'h1F);
        wr(8, 1); set_cnt(16'h1234);
        @(negedge clk); cap_in[0] = 1'b1; repeat (4) @(negedge clk);
        rd(9, v);  check("R6 rise capture lo", 16'(v), 16'h34);
        rd(10, v); check("R6 rise capture hi", 16'(v), 16'h12);
        check("R6 capture flag", 16'(irq[0]), 16'd1);
        wr(3, 8'h01); set_cnt(16'h2222);
        @(negedge clk); cap_in[0] = 1'b0; repeat (4) @(negedge clk);
        rd(9, v); check("R6 fall ignored in rise mode", 16'(v), 16'h34);
        check("R6 no flag on wrong edge", 16'(irq[0]), 16'd0);
        wr(8, 2); set_cnt(16'h3333);
        @(negedge clk); cap_in[0] = 1'b1; repeat (4) @(negedge clk);
        rd(10, v); check("R6 rise ignored in fall mode", 16'(v), 16'h12);
        @(negedge clk); cap_in[0] = 1'b0; repeat (4) @(negedge clk);
        rd(10, v); check("R6 fall capture", 16'(v), 16'h33);
        wr(8, 3); set_cnt(16'h4455);
        @(negedge clk); cap_in[0] = 1'b1; repeat (4) @(negedge clk);
        rd(9, v); check("R6 both mode rise", 16'(v), 16'h55);
        set_cnt(16'h6677);
        @(negedge clk); cap_in[0] = 1'b0; repeat (4) @(negedge clk);
        rd(9, v); check("R6 both mode fall", 16'(v), 16'h77);
        wr(8, 0); wr(3, 8'h1F);
    endtask

    task automatic t_wdog;
        wr(0, 8'h82); set_cnt(0);
        wr(9, 8'h02); wr(10, 8'h00); wr(8, 7);
        wr(25, 8'h03); wr(26, 8'h00); wr(24, 7);
        t0_pulses(2);
        check("R12 lower unit ignores mode 7", 16'(wdt_rst), 16'd0);
        wr(25, 8'h10);
        t0_pulses(13);
        check("R12 moved compare avoids reset", 16'(wdt_rst), 16'd0);
        t0_pulses(1);
        check("R12 reset on match", 16'(wdt_rst), 16'd1);
        wr(24, 0);
        repeat (3) @(negedge clk);
        check("R12 request sticky", 16'(wdt_rst), 16'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_div;
        t_hold;
        t_t0;
        t_ext;
        t_timer;
        t_toggle;
        t_pwm;
        t_capture;
        t_wdog;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule